// File: doc/BRIEF.md
# Byte-Bus UART Register Interface

This block is the processor-side register file of a classic byte-wide UART. Software reaches it through a 3-bit offset with separate read and write strobes. Behind the registers sit two 16-entry byte queues. The transmit queue feeds a separate serializer through a valid/ready byte stream. The receive queue is filled by a separate deserializer, which presents one byte per cycle with a valid strobe and accepts no back-pressure. The block also drives the 16-bit baud divisor and the line-format byte out to those engines. A single level interrupt output reports pending receive data or an empty transmit queue.

Some offsets decode differently for reads and writes. When bit 7 of the line-format register (the divisor-access bit) is set, offsets 0 and 1 reach the divisor bytes instead of the data and enable registers. A small state machine keeps the interrupt source that is currently reported. Its states are IRQ_NONE, IRQ_RX and IRQ_TX. It moves every cycle to the highest-priority live condition, so every transition can occur: NONE to RX, NONE to TX, RX to TX, TX to RX, RX to NONE and TX to NONE. Because this state is registered, the interrupt output and the identification value follow their conditions one cycle later.

Top module: `uart_regif`

## Requirements
- R1: After reset the divisor is 0x0000, the line-format byte is 0x00 and the enable register reads 0x00. Both queues are empty, line status reads 0x60 and the identification register reads 0x01.
- R2: With the divisor-access bit clear, a write to offset 0 queues a transmit byte and a read of offset 0 returns the receive head. Offset 1 is the enable register, which reads back bits 1:0 with zeros above. Offset 3 reads back the full line-format byte. Offsets 4, 6 and 7 read 0x00.
- R3: With line-format bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. The divisor output is {high, low}.
- R4: The line-format output always equals the last value written to offset 3. Value 0x03 means 8-bit words with no parity, with the word length in bits 1:0.
- R5: A write to offset 2 stores bit 0 as the queue-enable flag, which makes identification bits 7:6 read 11. In the same write, bit 1 empties the receive queue and bit 2 empties the transmit queue. Neither flush bit is stored.
- R6: Line status bit 0 is 1 while the receive queue holds a byte. Each read of offset 0 pops one byte, oldest first. Bit 0 clears once the queue is empty.
- R7: Line status bit 5 is 1 while the transmit queue has fewer than 16 bytes, and bit 6 is 1 while it is empty. A write to a full transmit queue is dropped.
- R8: A received byte that arrives while the receive queue holds 16 bytes is lost and sets line status bit 1. Bit 1 stays set until line status is read.
- R9: While the enable register is 0x00, the interrupt output is low in the following cycle.
- R10: The identification value is {queue-enable twice, 00, source, not-pending}. The source code is 010 for receive data (enable bit 0 set and the receive queue not empty) and 001 for transmit empty (enable bit 1 set and the empty flag set). Receive data wins over transmit empty. The interrupt output is high whenever a source is reported.
- R11: The transmit-empty flag is set at reset and whenever the transmit queue goes from non-empty to empty. It is cleared by a write to offset 0, or by reading the identification register while transmit empty is the reported source.
- R12: The transmit stream presents the oldest queued byte with tx_valid high. A byte leaves the queue on each cycle where tx_valid and tx_ready are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while rd_en is high |
| irq | output | 1 | Interrupt request, level |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Serializer takes tx_data |
| rx_data | input | 8 | Byte from the deserializer |
| rx_valid | input | 1 | rx_data is presented this cycle |
| divisor | output | 16 | Baud divisor to the bit-timing engines |
| line_ctrl | output | 8 | Line-format byte to the bit-timing engines |

## Verification
The bench pushes both queues to exactly 16 bytes and then adds one more. A design with an off-by-one depth would accept the extra transmit byte, or would flag overrun one byte early or one byte late. It keeps receive data pending while transmit empty is also live and reads the identification register. A wrong priority would report 001 there, and a clear that ignored the reported source would wipe the empty flag on a receive-data read. The bench toggles the divisor-access bit around data accesses, so a missing direction or access-bit decode would corrupt the divisor or the queues. It also re-arms transmit empty by draining the queue, and checks that a data write drops the interrupt.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_FIFO = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LFMT = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_LSTS = 3'd5;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'd0,
        IRQ_RX   = 2'd1,
        IRQ_TX   = 2'd2
    } irq_state_t;

    localparam logic [2:0] SRC_RX = 3'b010;
    localparam logic [2:0] SRC_TX = 3'b001;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             drained,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = empty ? '0 : mem[rd_ptr];
    assign count   = cnt_q;

    always_comb begin
        if (flush) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    assign drained = (cnt_q != '0) && (cnt_d == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (do_push) wr_ptr <= wr_ptr + 1'b1;
                if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ien,
    input  logic       rx_nonempty,
    input  logic       tx_drained,
    input  logic       thr_write,
    input  logic       id_read,
    output irq_state_t state,
    output logic       thre_flag,
    output logic       irq,
    output logic [2:0] src_code
);
    irq_state_t state_d;
    logic       rx_cond, tx_cond;

    assign rx_cond = ien[0] && rx_nonempty;
    assign tx_cond = ien[1] && thre_flag;

    always_comb begin
        state_d = state;
        unique case (state)
            IRQ_NONE: begin
                if (rx_cond)      state_d = IRQ_RX;
                else if (tx_cond) state_d = IRQ_TX;
            end
            IRQ_RX: begin
                if (!rx_cond)     state_d = tx_cond ? IRQ_TX : IRQ_NONE;
            end
            IRQ_TX: begin
                if (rx_cond)      state_d = IRQ_RX;
                else if (!tx_cond) state_d = IRQ_NONE;
            end
            default:              state_d = IRQ_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IRQ_NONE;
        end else begin
            state <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thre_flag <= 1'b1;
        end else if (tx_drained) begin
            thre_flag <= 1'b1;
        end else if (thr_write || (id_read && state == IRQ_TX)) begin
            thre_flag <= 1'b0;
        end
    end

    always_comb begin
        irq      = 1'b0;
        src_code = 3'b000;
        unique case (state)
            IRQ_NONE: ;
            IRQ_RX:   begin irq = 1'b1; src_code = SRC_RX; end
            IRQ_TX:   begin irq = 1'b1; src_code = SRC_TX; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic [2*DATA_W-1:0] divisor,
    output logic [DATA_W-1:0] line_ctrl
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic [DATA_W-1:0] div_lo_q, div_hi_q, lfmt_q;
    logic [1:0]        ien_q;
    logic              fen_q, ovr_q;
    logic              dlab;
    logic              thr_wr, dll_wr, dlm_wr, ien_wr, fifo_wr, lfmt_wr;
    logic              rhr_rd, id_rd, lsts_rd;
    logic              rx_flush, tx_flush;
    logic [DATA_W-1:0] rx_head;
    logic              rx_empty, rx_full, rx_drained;
    logic              tx_empty, tx_full, tx_drained;
    logic [CW-1:0]     rx_count, tx_count;
    irq_state_t        irq_state;
    logic              thre_flag;
    logic [2:0]        src_code;

    assign dlab    = lfmt_q[7];
    assign thr_wr  = wr_en && addr == OFS_DATA && !dlab;
    assign dll_wr  = wr_en && addr == OFS_DATA &&  dlab;
    assign dlm_wr  = wr_en && addr == OFS_IEN  &&  dlab;
    assign ien_wr  = wr_en && addr == OFS_IEN  && !dlab;
    assign fifo_wr = wr_en && addr == OFS_FIFO;
    assign lfmt_wr = wr_en && addr == OFS_LFMT;
    assign rhr_rd  = rd_en && addr == OFS_DATA && !dlab;
    assign id_rd   = rd_en && addr == OFS_FIFO;
    assign lsts_rd = rd_en && addr == OFS_LSTS;
    assign rx_flush = fifo_wr && wdata[1];
    assign tx_flush = fifo_wr && wdata[2];

    uart_byte_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_valid), .push_data(rx_data), .pop(rhr_rd), .flush(rx_flush),
        .head(rx_head), .empty(rx_empty), .full(rx_full),
        .drained(rx_drained), .count(rx_count)
    );

    uart_byte_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(thr_wr), .push_data(wdata), .pop(tx_valid && tx_ready),
        .flush(tx_flush),
        .head(tx_data), .empty(tx_empty), .full(tx_full),
        .drained(tx_drained), .count(tx_count)
    );

    assign tx_valid = !tx_empty;

    uart_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n),
        .ien(ien_q), .rx_nonempty(!rx_empty), .tx_drained(tx_drained),
        .thr_write(thr_wr), .id_read(id_rd),
        .state(irq_state), .thre_flag(thre_flag), .irq(irq),
        .src_code(src_code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_lo_q <= '0;
            div_hi_q <= '0;
            lfmt_q   <= '0;
            ien_q    <= '0;
            fen_q    <= 1'b0;
        end else begin
            if (dll_wr)  div_lo_q <= wdata;
            if (dlm_wr)  div_hi_q <= wdata;
            if (lfmt_wr) lfmt_q   <= wdata;
            if (ien_wr)  ien_q    <= wdata[1:0];
            if (fifo_wr) fen_q    <= wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (rx_valid && rx_full && !rx_flush) begin
            ovr_q <= 1'b1;
        end else if (lsts_rd) begin
            ovr_q <= 1'b0;
        end
    end

    assign divisor   = {div_hi_q, div_lo_q};
    assign line_ctrl = lfmt_q;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                OFS_DATA: rdata = dlab ? div_lo_q : rx_head;
                OFS_IEN:  rdata = dlab ? div_hi_q : {6'b0, ien_q};
                OFS_FIFO: rdata = {fen_q, fen_q, 2'b00, src_code, !irq};
                OFS_LFMT: rdata = lfmt_q;
                OFS_LSTS: rdata = {1'b0, tx_empty, !tx_full, 3'b000, ovr_q, !rx_empty};
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
    import uart_regif_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic [1:0]  ien_q,
    input logic        rx_valid,
    input logic        rx_full,
    input logic        rx_flush,
    input logic        rx_empty,
    input logic        ovr_q,
    input logic        dll_wr,
    input logic [7:0]  wdata,
    input logic [15:0] divisor,
    input irq_state_t  irq_state,
    input logic        thr_wr,
    input logic        tx_full,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_flush,
    input logic        tx_drained,
    input logic        thre_flag,
    input logic [$clog2(FIFO_DEPTH):0] tx_count,
    input logic [$clog2(FIFO_DEPTH):0] rx_count
);
    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == 2'b00) |=> !irq);

    // R7
    tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && tx_full && !(tx_valid && tx_ready) && !tx_flush) |=> (tx_count == $past(tx_count)));

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_full && !rx_flush) |=> ovr_q);

    // R3
    div_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dll_wr |=> (divisor[7:0] == $past(wdata)));

    // R10
    rx_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q[0] && !rx_empty) |=> (irq_state == IRQ_RX));

    // R5
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (tx_count == '0));

    // R11
    thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !tx_drained) |=> !thre_flag);

    // R6
    rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= ($clog2(FIFO_DEPTH)+1)'(FIFO_DEPTH));
endmodule

bind uart_regif uart_regif_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ien_q(ien_q),
    .rx_valid(rx_valid), .rx_full(rx_full), .rx_flush(rx_flush),
    .rx_empty(rx_empty), .ovr_q(ovr_q), .dll_wr(dll_wr), .wdata(wdata),
    .divisor(divisor), .irq_state(irq_state), .thr_wr(thr_wr),
    .tx_full(tx_full), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_flush(tx_flush), .tx_drained(tx_drained), .thre_flag(thre_flag),
    .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/uart_regif_tb.sv
`timescale 1ns/100ps
module uart_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic [15:0] divisor;
    logic [7:0]  line_ctrl;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_regif u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .divisor(divisor), .line_ctrl(line_ctrl)
    );

    // behavioural reference model
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [7:0] m_lo, m_hi, m_lfmt;
    logic [1:0] m_ien;
    bit m_fen, m_ovr, m_thre;
    int m_src; // 0 none, 1 receive data, 2 transmit empty
    int txn, rxn, nsrc;
    bit dl, txfl, rxfl, thrw;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_lo = 0; m_hi = 0; m_lfmt = 0; m_ien = 0;
            m_fen = 0; m_ovr = 0; m_thre = 1; m_src = 0;
        end else begin
            txn = txq.size(); rxn = rxq.size();
            if (m_ien[0] && rxn > 0) nsrc = 1;
            else if (m_ien[1] && m_thre) nsrc = 2;
            else nsrc = 0;
            dl   = m_lfmt[7];
            txfl = wr_en && addr == 3'd2 && wdata[2];
            rxfl = wr_en && addr == 3'd2 && wdata[1];
            thrw = wr_en && addr == 3'd0 && !dl;
            if (rx_valid && rxn == 16 && !rxfl) m_ovr = 1;
            else if (rd_en && addr == 3'd5) m_ovr = 0;
            if (rxfl) rxq.delete();
            else begin
                if (rd_en && addr == 3'd0 && !dl && rxn > 0) void'(rxq.pop_front());
                if (rx_valid && rxn < 16) rxq.push_back(rx_data);
            end
            if (txfl) txq.delete();
            else begin
                if (tx_ready && txn > 0) void'(txq.pop_front());
                if (thrw && txn < 16) txq.push_back(wdata);
            end
            if (txn > 0 && txq.size() == 0) m_thre = 1;
            else if (thrw || (rd_en && addr == 3'd2 && m_src == 2)) m_thre = 0;
            if (wr_en) begin
                case (addr)
                    3'd0: if (dl) m_lo = wdata;
                    3'd1: if (dl) m_hi = wdata; else m_ien = wdata[1:0];
                    3'd2: m_fen = wdata[0];
                    3'd3: m_lfmt = wdata;
                    default: ;
                endcase
            end
            m_src = nsrc;
        end
    end

    function automatic logic [7:0] exp_rdata();
        logic [7:0] v;
        v = 8'h00;
        case (addr)
            3'd0: v = m_lfmt[7] ? m_lo : (rxq.size() > 0 ? rxq[0] : 8'h00);
            3'd1: v = m_lfmt[7] ? m_hi : {6'b0, m_ien};
            3'd2: v = {m_fen, m_fen, 2'b00,
                       (m_src == 1) ? 3'b010 : (m_src == 2) ? 3'b001 : 3'b000,
                       m_src == 0};
            3'd3: v = m_lfmt;
            3'd5: v = {1'b0, txq.size() == 0, txq.size() < 16, 3'b000, m_ovr, rxq.size() > 0};
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R10", "irq", irq, m_src != 0);
            check("R12", "tx_valid", tx_valid, txq.size() > 0);
            if (txq.size() > 0) check("R12", "tx_data", tx_data, txq[0]);
            check("R3", "divisor", divisor, {m_hi, m_lo});
            check("R4", "line_ctrl", line_ctrl, m_lfmt);
            if (rd_en) begin
                case (addr)
                    3'd0: check(m_lfmt[7] ? "R3" : "R6", "rdata@0", rdata, exp_rdata());
                    3'd2: check("R10", "rdata@2", rdata, exp_rdata());
                    3'd5: check("R7", "rdata@5", rdata, exp_rdata());
                    default: check("R2", "rdata", rdata, exp_rdata());
                endcase
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rx_put(input logic [7:0] d);
        @(negedge clk);
        rx_data = d; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL R12 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "divisor", divisor, 16'h0000);
        check("R1", "line_ctrl", line_ctrl, 8'h00);
        check("R1", "tx_valid", tx_valid, 0);
        rd(3'd5, v); check("R1", "lsr", v, 8'h60);
        rd(3'd1, v); check("R1", "ier", v, 8'h00);
        rd(3'd2, v); check("R1", "iir", v, 8'h01);
        rd(3'd6, v); check("R2", "unused offset", v, 8'h00);

        // R3 divisor access
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h12);
        rd(3'd0, v); check("R3", "div lo", v, 8'h03);
        rd(3'd1, v); check("R3", "div hi", v, 8'h12);
        check("R3", "divisor out", divisor, 16'h1203);
        check("R3", "tx_valid after dlab write", tx_valid, 0);
        wr(3'd3, 8'h03);
        check("R4", "line_ctrl 8N", line_ctrl, 8'h03);
        rd(3'd3, v); check("R2", "lcr readback", v, 8'h03);
        rd(3'd1, v); check("R2", "ier after dlab clear", v, 8'h00);

        // R5 enable queues
        wr(3'd2, 8'h07);
        rd(3'd2, v); check("R5", "iir fifo bits", v, 8'hC1);

        // R7 fill transmit queue
        wr(3'd0, 8'hA1); wr(3'd0, 8'hA2); wr(3'd0, 8'hA3);
        check("R12", "head byte", tx_data, 8'hA1);
        rd(3'd5, v); check("R7", "lsr partly full", v, 8'h20);
        for (int i = 3; i < 16; i++) wr(3'd0, 8'hB0 + 8'(i));
        rd(3'd5, v); check("R7", "lsr full", v, 8'h00);
        wr(3'd0, 8'hEE);
        tx_ready = 1'b1;
        while (tx_valid) @(negedge clk);
        tx_ready = 1'b0;
        rd(3'd5, v); check("R7", "lsr drained", v, 8'h60);

        // R6 receive order
        rx_put(8'h11); rx_put(8'h22); rx_put(8'h33);
        rd(3'd5, v); check("R6", "lsr data ready", v, 8'h61);
        rd(3'd0, v); check("R6", "rx 1", v, 8'h11);
        rd(3'd0, v); check("R6", "rx 2", v, 8'h22);
        rd(3'd0, v); check("R6", "rx 3", v, 8'h33);
        rd(3'd5, v); check("R6", "lsr empty", v, 8'h60);

        // R8 overrun
        for (int i = 0; i < 17; i++) rx_put(8'h40 + 8'(i));
        rd(3'd5, v); check("R8", "lsr overrun", v, 8'h63);
        rd(3'd5, v); check("R8", "overrun cleared", v, 8'h61);
        wr(3'd2, 8'h03);
        rd(3'd5, v); check("R5", "rx flushed", v, 8'h60);

        // R9 masked
        wr(3'd1, 8'h00);
        rx_put(8'h5A);
        repeat (2) @(negedge clk);
        check("R9", "irq masked", irq, 0);

        // R10 priority, R11 clear on id read
        wr(3'd1, 8'h03);
        @(negedge clk);
        check("R10", "irq rx", irq, 1);
        rd(3'd2, v); check("R10", "iir rx wins", v, 8'hC4);
        rd(3'd0, v); check("R6", "rx byte", v, 8'h5A);
        rd(3'd2, v); check("R10", "iir thre", v, 8'hC2);
        rd(3'd2, v); check("R11", "iir after clear", v, 8'hC1);
        check("R11", "irq cleared", irq, 0);

        // R11 re-arm on drain and clear on data write
        tx_ready = 1'b1;
        wr(3'd0, 8'h55);
        repeat (3) @(negedge clk);
        check("R11", "irq re-armed", irq, 1);
        tx_ready = 1'b0;
        wr(3'd0, 8'h66);
        @(negedge clk);
        check("R11", "irq cleared by write", irq, 0);
        tx_ready = 1'b1;
        repeat (4) @(negedge clk);
        check("R11", "irq after drain", irq, 1);
        tx_ready = 1'b0;

        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule